// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

After reset this block fetches a 32-word image from a three-wire serial EEPROM and decides whether the image can be trusted. The first read also serves as a presence probe. Every word is then read with its own READ command. While the words arrive, the block keeps running sums and field checks. When the last word is in, it commits a 48-bit station address and sixteen 16-bit configuration words to its output bank, but only if every check passes.

If the probe finds no device, or if any check fails, the outputs keep their parameterised reset values and a status flag reports the reason. Once loading has finished, the host may program single words. The block sends the write-enable command, then the write command, and then waits on the device ready line until programming completes.

The serial clock is the system clock divided by `2*CLK_DIV`. The serial engine, the image checker and the control path are separate modules.

Top module: `nvcfg_loader`

## Requirements
- R1: While reset is held and right after it: chip select and serial clock are low, `done_o`, `err_o` and `absent_o` are low, and `busy_o` is high because loading starts at once.
- R2: Word n (n = 0 to 31, in rising order) is read with one frame. The frame carries a 1 start bit, opcode bits 1,0 and a 6-bit address, all sent MSB first. It then has 17 more clocks: a dummy bit and 16 data bits, MSB first. A frame therefore has 26 serial-clock rises, spaced 2*CLK_DIV system clocks apart. The data-out line changes only while the serial clock is low.
- R3: If the dummy bit of the first frame reads 1, `absent_o` rises. No further frame is sent, `err_o` and `done_o` stay low, and the outputs keep their reset values.
- R4: Image byte k sits in word k/2: the low byte for even k and the high byte for odd k. Bytes 0 to 5 load `sta_addr_o`, with byte k at bits 8k+7:8k.
- R5: Words 8 to 23 load `cfg_o`, with word 8+j at bits 16j+15:16j.
- R6: Word 6 must equal the 16-bit sum of bytes 0 to 11, 14 and 15.
- R7: The 8-bit sum of all 64 bytes must equal FFh.
- R8: Bytes 6, 7 and 8 must be 00h, and byte 9 must be 11h.
- R9: Bytes 14 and 15 must both be 57h.
- R10: If every check passes, `done_o` pulses for one cycle, and the outputs take their new values on the same edge. If any check fails, `err_o` rises and stays high, `done_o` stays low, and the outputs keep their reset values.
- R11: After loading ends, a `wr_req_i` pulse starts three steps while `busy_o` is high. First a write-enable frame (1, 00, 11 followed by four 0s). Then a write frame (1, 01, address, 16 data bits). Then chip select is held high until the device drives its data line to 1. A request made while `busy_o` is high is ignored.
- R12: The reset values of the outputs are the parameters `STA_RESET` and `CFG_RESET`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mw_cs_o | output | 1 | EEPROM chip select |
| mw_sk_o | output | 1 | EEPROM serial clock |
| mw_di_o | output | 1 | Serial data to the EEPROM |
| mw_do_i | input | 1 | Serial data from the EEPROM, pulled high when no device is fitted |
| wr_req_i | input | 1 | One-cycle request to program one word |
| wr_addr_i | input | ADDR_W | Word address to program |
| wr_data_i | input | 16 | Word value to program |
| sta_addr_o | output | 48 | Station address |
| cfg_o | output | 256 | Sixteen configuration words |
| done_o | output | 1 | One-cycle pulse when a valid image is committed |
| err_o | output | 1 | The image failed a check |
| absent_o | output | 1 | No EEPROM answered |
| busy_o | output | 1 | A load or a write is in progress |

## Verification
If the word counter goes wrong, it shows up on the data-out line within the same frame, as a wrong address or a wrong number of reads. A wrong accumulator or field flag shows up only at the end of the load, about 32 frames after reset, as `err_o` where `done_o` was expected, or the reverse. A wrong shadow-to-output mapping shows up on the same edge as the `done_o` pulse. Each validation rule is therefore tested alone, with an image that breaks only that rule while every other sum still matches.

// File: rtl/nvcfg_pkg.sv
package nvcfg_pkg;
   localparam int WORD_W    = 16;
   localparam int IMG_WORDS = 32;
   localparam int STA_WORDS = 3;
   localparam int CFG_WORDS = 16;
   localparam int CFG_FIRST = 8;
   localparam int CSUM_WORD = 6;
   localparam int SIG_WORD  = 7;
   localparam int RSV_WORD  = 3;
   localparam int ID_WORD   = 4;
   localparam logic [7:0] HW_ID    = 8'h11;
   localparam logic [7:0] SIG_BYTE = 8'h57;
   localparam logic [7:0] TOTAL_OK = 8'hFF;

   typedef enum logic [1:0] {
      OP_EXT   = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10
   } mw_op_e;

   typedef enum logic [3:0] {
      S_RD_GO, S_RD_WT, S_EVAL, S_READY,
      S_EW_GO, S_EW_WT, S_WR_GO, S_WR_WT, S_PL_GO, S_PL_WT
   } ctl_state_e;
endpackage

// File: rtl/nvcfg_mw_frame.sv
module nvcfg_mw_frame
   import nvcfg_pkg::*;
#(
   parameter int CLK_DIV = 2,
   parameter int FRAME_W = 25,
   parameter int CNT_W   = $clog2(FRAME_W + WORD_W + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               poll_i,
   input  logic [FRAME_W-1:0] tx_i,
   input  logic [CNT_W-1:0]   tx_len_i,
   input  logic [CNT_W-1:0]   rx_len_i,
   output logic               cs_o,
   output logic               sk_o,
   output logic               di_o,
   input  logic               do_i,
   output logic [WORD_W:0]    rx_o,
   output logic               done_o
);
   localparam int DIV_W = $clog2(CLK_DIV + 1);

   typedef enum logic [1:0] {F_IDLE, F_RUN, F_POLL, F_GAP} fst_e;

   fst_e               st_q;
   logic [DIV_W-1:0]   div_q;
   logic [FRAME_W-1:0] sh_q;
   logic [CNT_W-1:0]   cnt_q, ntx_q, ntot_q;
   logic               tick;

   assign tick = (div_q == DIV_W'(CLK_DIV - 1));
   assign di_o = (st_q == F_RUN) && (cnt_q < ntx_q) && sh_q[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= F_IDLE;
         div_q  <= '0;
         sh_q   <= '0;
         cnt_q  <= '0;
         ntx_q  <= '0;
         ntot_q <= '0;
         cs_o   <= 1'b0;
         sk_o   <= 1'b0;
         rx_o   <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (st_q)
            F_IDLE: if (start_i) begin
               cs_o   <= 1'b1;
               sk_o   <= 1'b0;
               sh_q   <= tx_i;
               ntx_q  <= tx_len_i;
               ntot_q <= tx_len_i + rx_len_i;
               cnt_q  <= '0;
               div_q  <= '0;
               rx_o   <= '0;
               st_q   <= poll_i ? F_POLL : F_RUN;
            end
            F_RUN: begin
               div_q <= tick ? '0 : div_q + 1'b1;
               if (tick) begin
                  if (!sk_o) begin
                     sk_o <= 1'b1;
                     if (cnt_q >= ntx_q) rx_o <= {rx_o[WORD_W-1:0], do_i};
                  end else begin
                     sk_o  <= 1'b0;
                     sh_q  <= sh_q << 1;
                     cnt_q <= cnt_q + 1'b1;
                     if (cnt_q == ntot_q - 1'b1) begin
                        cs_o <= 1'b0;
                        st_q <= F_GAP;
                     end
                  end
               end
            end
            F_POLL: if (do_i) begin
               cs_o  <= 1'b0;
               div_q <= '0;
               st_q  <= F_GAP;
            end
            default: begin
               div_q <= tick ? '0 : div_q + 1'b1;
               if (tick) begin
                  done_o <= 1'b1;
                  st_q   <= F_IDLE;
               end
            end
         endcase
      end
   end

   // R2: the serial clock only toggles while the device is selected
   p_sk_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sk_o |-> cs_o);
   // R2: data towards the device holds while the serial clock is high
   p_di_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sk_o && $past(sk_o)) |-> $stable(di_o));
endmodule

// File: rtl/nvcfg_check.sv
module nvcfg_check
   import nvcfg_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              pass_o
);
   logic [15:0] sum16_q, csum_q;
   logic [7:0]  sum8_q;
   logic        bad_q;
   logic [7:0]  lo, hi;

   assign lo = word_i[7:0];
   assign hi = word_i[15:8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum16_q <= '0;
         csum_q  <= '0;
         sum8_q  <= '0;
         bad_q   <= 1'b0;
      end else if (vld_i) begin
         sum8_q <= sum8_q + lo + hi;
         if (idx_i < IDX_W'(CFG_FIRST) && idx_i != IDX_W'(CSUM_WORD))
            sum16_q <= sum16_q + {8'h00, lo} + {8'h00, hi};
         if (idx_i == IDX_W'(CSUM_WORD)) csum_q <= word_i;
         if (idx_i == IDX_W'(RSV_WORD) && word_i != '0) bad_q <= 1'b1;
         if (idx_i == IDX_W'(ID_WORD) && (lo != 8'h00 || hi != HW_ID)) bad_q <= 1'b1;
         if (idx_i == IDX_W'(SIG_WORD) && (lo != SIG_BYTE || hi != SIG_BYTE)) bad_q <= 1'b1;
      end
   end

   // R6 R7 R8 R9
   assign pass_o = !bad_q && (sum16_q == csum_q) && (sum8_q == TOTAL_OK);
endmodule

// File: rtl/nvcfg_loader.sv
module nvcfg_loader
   import nvcfg_pkg::*;
#(
   parameter int                            CLK_DIV   = 2,
   parameter int                            ADDR_W    = 6,
   parameter bit                            WR_EN     = 1'b1,
   parameter logic [47:0]                   STA_RESET = '0,
   parameter logic [CFG_WORDS*WORD_W-1:0]   CFG_RESET = '0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   output logic                          mw_cs_o,
   output logic                          mw_sk_o,
   output logic                          mw_di_o,
   input  logic                          mw_do_i,
   input  logic                          wr_req_i,
   input  logic [ADDR_W-1:0]             wr_addr_i,
   input  logic [WORD_W-1:0]             wr_data_i,
   output logic [47:0]                   sta_addr_o,
   output logic [CFG_WORDS*WORD_W-1:0]   cfg_o,
   output logic                          done_o,
   output logic                          err_o,
   output logic                          absent_o,
   output logic                          busy_o
);
   localparam int FRAME_W = 3 + ADDR_W + WORD_W;
   localparam int CNT_W   = $clog2(FRAME_W + WORD_W + 2);
   localparam int IDX_W   = $clog2(IMG_WORDS);
   localparam int SH_N    = STA_WORDS + CFG_WORDS;
   localparam int CMD_W   = 3 + ADDR_W;

   if (CLK_DIV < 1) begin : g_bad_div
      $error("CLK_DIV must be at least 1");
   end
   if (ADDR_W < IDX_W) begin : g_bad_aw
      $error("ADDR_W too small for the image");
   end

   ctl_state_e            st_q;
   logic [IDX_W-1:0]      idx_q;
   logic [ADDR_W-1:0]     wa_q;
   logic [WORD_W-1:0]     wd_q;
   logic                  fr_start, fr_poll, fr_done;
   logic [FRAME_W-1:0]    fr_tx;
   logic [CNT_W-1:0]      fr_txlen, fr_rxlen;
   logic [WORD_W:0]       fr_rx;
   logic                  word_vld, no_dev, chk_pass, commit, wr_take;
   logic [SH_N*WORD_W-1:0] sh_flat;

   assign fr_start = (st_q == S_RD_GO) || (st_q == S_EW_GO) ||
                     (st_q == S_WR_GO) || (st_q == S_PL_GO);
   assign fr_poll  = (st_q == S_PL_GO);

   always_comb begin
      fr_tx    = '0;
      fr_txlen = CNT_W'(CMD_W);
      fr_rxlen = '0;
      case (st_q)
         S_RD_GO: begin
            fr_tx    = {1'b1, OP_READ, ADDR_W'(idx_q), {WORD_W{1'b0}}};
            fr_rxlen = CNT_W'(WORD_W + 1);
         end
         S_EW_GO: fr_tx = {1'b1, OP_EXT, 2'b11, {(ADDR_W-2){1'b0}}, {WORD_W{1'b0}}};
         S_WR_GO: begin
            fr_tx    = {1'b1, OP_WRITE, wa_q, wd_q};
            fr_txlen = CNT_W'(FRAME_W);
         end
         default: ;
      endcase
   end

   nvcfg_mw_frame #(.CLK_DIV(CLK_DIV), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .start_i(fr_start), .poll_i(fr_poll),
      .tx_i(fr_tx), .tx_len_i(fr_txlen), .rx_len_i(fr_rxlen),
      .cs_o(mw_cs_o), .sk_o(mw_sk_o), .di_o(mw_di_o), .do_i(mw_do_i),
      .rx_o(fr_rx), .done_o(fr_done)
   );

   // R3: a dummy bit of 1 on the first frame means no device answered
   assign no_dev   = (st_q == S_RD_WT) && fr_done && (idx_q == '0) && fr_rx[WORD_W];
   assign word_vld = (st_q == S_RD_WT) && fr_done && !no_dev;

   nvcfg_check #(.IDX_W(IDX_W)) u_check (
      .clk(clk), .rst_n(rst_n), .vld_i(word_vld), .idx_i(idx_q),
      .word_i(fr_rx[WORD_W-1:0]), .pass_o(chk_pass)
   );

   // R4 R5: shadow registers, one for each word that reaches the outputs
   for (genvar g = 0; g < SH_N; g++) begin : g_shadow
      localparam int SRC = (g < STA_WORDS) ? g : g - STA_WORDS + CFG_FIRST;
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else if (word_vld && idx_q == IDX_W'(SRC)) q <= fr_rx[WORD_W-1:0];
      end
      assign sh_flat[g*WORD_W +: WORD_W] = q;
   end

   if (WR_EN) begin : g_wr
      assign wr_take = wr_req_i && (st_q == S_READY);
   end else begin : g_nowr
      assign wr_take = 1'b0;
   end

   assign commit = (st_q == S_EVAL) && chk_pass;
   assign busy_o = (st_q != S_READY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= S_RD_GO;
         idx_q      <= '0;
         wa_q       <= '0;
         wd_q       <= '0;
         done_o     <= 1'b0;
         err_o      <= 1'b0;
         absent_o   <= 1'b0;
         sta_addr_o <= STA_RESET;
         cfg_o      <= CFG_RESET;
      end else begin
         done_o <= 1'b0;
         if (commit) begin
            sta_addr_o <= sh_flat[STA_WORDS*WORD_W-1:0];
            cfg_o      <= sh_flat[SH_N*WORD_W-1:STA_WORDS*WORD_W];
         end
         case (st_q)
            S_RD_GO: st_q <= S_RD_WT;
            S_RD_WT: if (fr_done) begin
               if (no_dev) begin
                  absent_o <= 1'b1;
                  st_q     <= S_READY;
               end else if (idx_q == IDX_W'(IMG_WORDS - 1)) begin
                  st_q <= S_EVAL;
               end else begin
                  idx_q <= idx_q + 1'b1;
                  st_q  <= S_RD_GO;
               end
            end
            S_EVAL: begin
               if (chk_pass) done_o <= 1'b1;
               else          err_o  <= 1'b1;
               st_q <= S_READY;
            end
            S_READY: if (wr_take) begin
               wa_q <= wr_addr_i;
               wd_q <= wr_data_i;
               st_q <= S_EW_GO;
            end
            S_EW_GO: st_q <= S_EW_WT;
            S_EW_WT: if (fr_done) st_q <= S_WR_GO;
            S_WR_GO: st_q <= S_WR_WT;
            S_WR_WT: if (fr_done) st_q <= S_PL_GO;
            S_PL_GO: st_q <= S_PL_WT;
            S_PL_WT: if (fr_done) st_q <= S_READY;
            default: st_q <= S_READY;
         endcase
      end
   end

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_not_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));
   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);
   p_regs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(sta_addr_o) && $stable(cfg_o)));
   p_absent_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
      absent_o |-> (!err_o && !mw_cs_o && sta_addr_o == STA_RESET));
endmodule

// File: tb/nvcfg_loader_tb.sv
module nvcfg_loader_tb;
   localparam int DIV = 2;
   localparam logic [47:0]  STA_DEF = 48'h0000_1111_2222;
   localparam logic [255:0] CFG_DEF = {16{16'hC0DE}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs, sk, mw_di, mw_do;
   logic wr_req = 1'b0;
   logic [5:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [47:0] sta;
   logic [255:0] cfg;
   logic done, err, absent, busy;

   always #10 clk = ~clk;

   nvcfg_loader #(.CLK_DIV(DIV), .STA_RESET(STA_DEF), .CFG_RESET(CFG_DEF)) u_dut (
      .clk(clk), .rst_n(rst_n), .mw_cs_o(cs), .mw_sk_o(sk), .mw_di_o(mw_di),
      .mw_do_i(mw_do), .wr_req_i(wr_req), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .sta_addr_o(sta), .cfg_o(cfg), .done_o(done), .err_o(err),
      .absent_o(absent), .busy_o(busy)
   );

   int n_tests = 0, n_fail = 0;
   logic [15:0] img [32];
   bit present = 1'b1;
   bit mdl_load = 1'b0;

   // ---------------- behavioural EEPROM ----------------
   logic [15:0] mem [32];
   logic do_r = 1'b1, sk_p = 1'b0, cs_p = 1'b0, di_p = 1'b0;
   logic [24:0] cmd = '0;
   logic rd_on = 1'b0, dummy_sent = 1'b0, we = 1'b0;
   logic [15:0] rd_sh = '0;
   int bits = 0, last_rise = 0, cyc = 0, busy_cnt = 0;
   int frame_err = 0, per_err = 0, di_err = 0, rd_cnt = 0, wr_cnt = 0;
   int rd_log [32];

   assign mw_do = !present ? 1'b1 : (busy_cnt > 0 ? 1'b0 : do_r);

   always @(negedge clk) begin
      cyc++;
      if (mdl_load) begin
         for (int i = 0; i < 32; i++) mem[i] = img[i];
         frame_err = 0; per_err = 0; di_err = 0; rd_cnt = 0; wr_cnt = 0;
         we = 1'b0; busy_cnt = 0; do_r = 1'b1;
      end
      if (busy_cnt > 0) busy_cnt--;
      if (cs && !cs_p) begin bits = 0; cmd = '0; rd_on = 1'b0; dummy_sent = 1'b0; end
      if (cs && sk && !sk_p) begin
         if (bits > 0 && cyc - last_rise != 2 * DIV) per_err++;
         last_rise = cyc;
         cmd = {cmd[23:0], mw_di};
         bits++;
         if (bits == 9 && cmd[8:6] == 3'b110) begin
            rd_on = 1'b1;
            rd_sh = mem[cmd[4:0]];
            if (rd_cnt < 32) rd_log[rd_cnt] = int'(cmd[5:0]);
            rd_cnt++;
         end
      end
      if (sk && sk_p && mw_di != di_p) di_err++;
      if (cs && !sk && sk_p && rd_on) begin
         if (!dummy_sent) begin do_r = 1'b0; dummy_sent = 1'b1; end
         else begin do_r = rd_sh[15]; rd_sh = {rd_sh[14:0], 1'b0}; end
      end
      if (!cs && cs_p) begin
         if (rd_on && bits != 26) frame_err++;
         if (!rd_on && bits == 9 && cmd[8:4] == 5'b10011) we = 1'b1;
         else if (!rd_on && bits == 25 && cmd[24:22] == 3'b101 && we) begin
            mem[cmd[20:16]] = cmd[15:0];
            wr_cnt++;
            busy_cnt = 40;
         end
         do_r = 1'b1;
         rd_on = 1'b0;
      end
      sk_p = sk; cs_p = cs; di_p = mw_di;
   end

   // ---------------- watchdog ----------------
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 190000) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 190000)", wd);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] gb(int k);
      return img[k >> 1][(k & 1) * 8 +: 8];
   endfunction

   task automatic sb(int k, logic [7:0] v);
      img[k >> 1][(k & 1) * 8 +: 8] = v;
   endtask

   task automatic fix_total();
      logic [7:0] t = 8'h00;
      for (int k = 0; k < 63; k++) t = t + gb(k);
      sb(63, 8'hFF - t);
   endtask

   task automatic fix_sums();
      logic [15:0] s = 16'h0000;
      for (int k = 0; k < 12; k++) s = s + 16'(gb(k));
      s = s + 16'(gb(14)) + 16'(gb(15));
      img[6] = s;
      fix_total();
   endtask

   task automatic mk_valid();
      logic [7:0] st [6] = '{8'h02, 8'h1A, 8'h2B, 8'h3C, 8'h4D, 8'h5E};
      for (int i = 0; i < 32; i++) img[i] = 16'h0000;
      for (int k = 0; k < 6; k++) sb(k, st[k]);
      img[4] = 16'h1100;
      img[5] = 16'h6E21;
      img[7] = 16'h5757;
      for (int j = 0; j < 16; j++) img[8 + j] = {8'(8'h30 + j), 8'(8'h90 + 3 * j)};
      fix_sums();
   endtask

   function automatic logic [47:0] exp_sta();
      logic [47:0] v;
      for (int k = 0; k < 6; k++) v[8 * k +: 8] = gb(k);
      return v;
   endfunction

   function automatic logic [255:0] exp_cfg();
      logic [255:0] v;
      for (int j = 0; j < 16; j++) v[16 * j +: 16] = img[8 + j];
      return v;
   endfunction

   task automatic start_run(bit pres);
      rst_n = 1'b0;
      present = pres;
      mdl_load = 1'b1;
      repeat (3) @(negedge clk);
      mdl_load = 1'b0;
      rst_n = 1'b1;
   endtask

   task automatic wait_end();
      int n = 0;
      @(negedge clk);
      while (!(done || err || absent) && n < 20000) begin @(negedge clk); n++; end
   endtask

   task automatic expect_reject(string req);
      start_run(1'b1);
      wait_end();
      chk({req, " err raised"}, 256'(err), 256'(1));
      chk({req, " no done"}, 256'(done), 256'(0));
      repeat (8) @(negedge clk);
      chk({req, " done stays low (R10)"}, 256'(done), 256'(0));
      chk({req, " station default (R10)"}, 256'(sta), 256'(STA_DEF));
      chk({req, " cfg default (R10)"}, cfg, CFG_DEF);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset_state();
      mk_valid();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 cs low", 256'(cs), 256'(0));
      chk("R1 sk low", 256'(sk), 256'(0));
      chk("R1 flags low", 256'({done, err, absent}), 256'(0));
      chk("R1 busy high", 256'(busy), 256'(1));
      chk("R12 station reset value", 256'(sta), 256'(STA_DEF));
      chk("R12 cfg reset value", cfg, CFG_DEF);
   endtask

   task automatic t_good_load();
      mk_valid();
      start_run(1'b1);
      wait_end();
      chk("R10 done pulse", 256'(done), 256'(1));
      chk("R10 no error", 256'({err, absent}), 256'(0));
      chk("R4 station address", 256'(sta), 256'(exp_sta()));
      chk("R5 config words", cfg, exp_cfg());
      @(negedge clk);
      chk("R10 done single cycle", 256'(done), 256'(0));
      chk("R2 read count", 256'(rd_cnt), 256'(32));
      for (int i = 0; i < 32; i++)
         if (rd_log[i] != i) chk("R2 read address order", 256'(rd_log[i]), 256'(i));
      chk("R2 clocks per frame", 256'(frame_err), 256'(0));
      chk("R2 serial clock period", 256'(per_err), 256'(0));
      chk("R2 data held while clock high", 256'(di_err), 256'(0));
   endtask

   task automatic t_bad_sum();
      mk_valid();
      img[6] = img[6] ^ 16'h0100;
      fix_total();
      expect_reject("R6");
   endtask

   task automatic t_bad_total();
      mk_valid();
      sb(63, gb(63) ^ 8'h01);
      expect_reject("R7");
   endtask

   task automatic t_bad_id();
      mk_valid();
      sb(9, 8'h12);
      fix_sums();
      expect_reject("R8 id");
   endtask

   task automatic t_bad_reserved();
      mk_valid();
      sb(7, 8'h01);
      fix_sums();
      expect_reject("R8 reserved");
   endtask

   task automatic t_bad_sig();
      mk_valid();
      sb(14, 8'h58);
      fix_sums();
      expect_reject("R9");
   endtask

   task automatic t_absent();
      mk_valid();
      start_run(1'b0);
      wait_end();
      chk("R3 absent flag", 256'(absent), 256'(1));
      chk("R3 no err no done", 256'({err, done}), 256'(0));
      repeat (20) @(negedge clk);
      chk("R3 single probe frame", 256'(rd_cnt), 256'(1));
      chk("R3 station default", 256'(sta), 256'(STA_DEF));
      chk("R3 cfg default", cfg, CFG_DEF);
   endtask

   task automatic t_write();
      int n = 0;
      mk_valid();
      start_run(1'b1);
      @(negedge clk);
      wr_req = 1'b1; wr_addr = 6'd3; wr_data = 16'hFFFF;
      @(negedge clk);
      wr_req = 1'b0;
      wait_end();
      repeat (4) @(negedge clk);
      chk("R11 request during load ignored", 256'(mem[3]), 256'(img[3]));
      chk("R11 no write during load", 256'(wr_cnt), 256'(0));
      wr_req = 1'b1; wr_addr = 6'd5; wr_data = 16'hA5C3;
      @(negedge clk);
      wr_req = 1'b0;
      chk("R11 busy during write", 256'(busy), 256'(1));
      while (busy && n < 5000) begin @(negedge clk); n++; end
      chk("R11 write enable seen", 256'(we), 256'(1));
      chk("R11 word programmed", 256'(mem[5]), 256'(16'hA5C3));
      chk("R11 one write", 256'(wr_cnt), 256'(1));
      chk("R11 ready waited", 256'(busy_cnt), 256'(0));
   endtask

   initial begin
      t_reset_state();
      t_good_load();
      t_bad_sum();
      t_bad_total();
      t_bad_id();
      t_bad_reserved();
      t_bad_sig();
      t_absent();
      t_write();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule